// File: doc/BRIEF.md
# Fault-Tolerant Vector Load Sequencer

This block sequences one vector load at a time, where only the leading element is guaranteed to succeed. A start pulse hands it a base address, a stride and a requested element count. It then issues one element request per accepted handshake to a memory port. Element k uses address base + k*stride. Each response carries data or a fault flag. Good data goes straight to a destination slot whose index equals the element number.

When every element succeeds, the full count is reported. A fault on a later element quietly shortens the vector: issuing stops at once, responses that are still in flight are drained but not written, and the reported length is the number of elements finished before the fault. A fault on element 0 cannot be absorbed this way. It raises a trap, and the reported length stays at the requested value.

Top module: `ffload_seq`

## Requirements
- R1: While reset is held and right after it: req_valid_o, rsp_ready_o, wr_en_o, done_o and trap_o are 0, and loaded_cnt_o is 0.
- R2: The n-th accepted request of an operation carries address base + n*stride, modulo 2^AW. Requests go out in increasing element order, and an unaccepted request holds its address.
- R3: The effective count is min(count_i, MAX_ELEMS). No more requests than the effective count are issued.
- R4: A response without a fault, taken before any fault, drives wr_en_o=1 in the same cycle. In that cycle wr_idx_o equals the element index and wr_data_o equals rsp_data_i. No other cycle writes.
- R5: With no fault, done_o rises in the cycle after the last response handshake. loaded_cnt_o then equals the effective count and trap_o is 0.
- R6: A fault on element 0 gives trap_o=1, loaded_cnt_o equal to the effective count, and no destination write for that element.
- R7: A fault on element k>0 gives loaded_cnt_o=k and trap_o=0. From the cycle of the fault onward, req_valid_o stays 0. Outstanding responses are accepted without any write. done_o rises the cycle after the last outstanding response.
- R8: An effective count of 0 raises done_o in the cycle after start, with loaded_cnt_o=0, trap_o=0 and no request.
- R9: start_i is ignored while an operation is running. Addresses, writes and results of the running operation are unaffected.
- R10: done_o is a one-cycle pulse. loaded_cnt_o and trap_o hold until the next accepted start, which clears them to 0.
- R11: rsp_ready_o is 1 from the cycle after an accepted start until the final response. It is 0 when idle, including the cycle done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| base_i | input | AW | Address of element 0 |
| stride_i | input | AW | Address step between elements |
| count_i | input | CW | Requested element count |
| req_valid_o | output | 1 | Element request valid |
| req_addr_o | output | AW | Element request address |
| req_ready_i | input | 1 | Memory accepts request |
| rsp_valid_i | input | 1 | Response valid |
| rsp_data_i | input | DW | Response data |
| rsp_fault_i | input | 1 | Response reports a fault |
| rsp_ready_o | output | 1 | Block accepts response |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | IW | Destination slot index |
| wr_data_o | output | DW | Destination write data |
| done_o | output | 1 | Operation complete (pulse) |
| loaded_cnt_o | output | CW | Elements actually loaded |
| trap_o | output | 1 | First element faulted |

## Verification
Request, ready and write outputs are combinational on the current handshake inputs, so they are due in the same cycle the bench drives the response. The bench drives on the falling edge and samples one time unit later. done_o, loaded_cnt_o and trap_o are registered and due exactly one cycle after the final response handshake, or after start for a zero count. The bench therefore predicts the completion cycle from its own handshake tally and requires done_o in precisely that sample, and in no other.

// File: rtl/ffload_pkg.sv
package ffload_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_st_e;
endpackage

// File: rtl/ffload_issue.sv
module ffload_issue #(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic          run_i,
  input  logic [CW-1:0] total_i,
  input  logic          req_ready_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  output logic [CW-1:0] issued_o
);
  logic [AW-1:0] addr_q, stride_q;
  logic [CW-1:0] issued_q;

  assign req_valid_o = run_i && (issued_q < total_i);
  assign req_addr_o  = addr_q;
  assign issued_o    = issued_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      stride_q <= '0;
      issued_q <= '0;
    end else if (load_i) begin
      addr_q   <= base_i;
      stride_q <= stride_i;
      issued_q <= '0;
    end else if (req_valid_o && req_ready_i) begin
      addr_q   <= addr_q + stride_q;
      issued_q <= issued_q + 1'b1;
    end
  end
endmodule

// File: rtl/ffload_retire.sv
module ffload_retire #(
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          active_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          rsp_fault_i,
  output logic          rsp_ready_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [DW-1:0] wr_data_o,
  output logic [CW-1:0] rcvd_o,
  output logic          halt_o,
  output logic [CW-1:0] fault_idx_o
);
  logic          fire;
  logic          fault_q;
  logic [CW-1:0] rcvd_q, trunc_q;

  assign rsp_ready_o = active_i;
  assign fire        = rsp_valid_i && rsp_ready_o;
  // writes stop for good once any fault has been taken
  assign wr_en_o     = fire && !rsp_fault_i && !fault_q;
  assign wr_idx_o    = rcvd_q[IW-1:0];
  assign wr_data_o   = rsp_data_i;
  assign rcvd_o      = rcvd_q;
  assign halt_o      = fault_q || (fire && rsp_fault_i);
  assign fault_idx_o = fault_q ? trunc_q : rcvd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcvd_q  <= '0;
      trunc_q <= '0;
      fault_q <= 1'b0;
    end else if (load_i) begin
      rcvd_q  <= '0;
      trunc_q <= '0;
      fault_q <= 1'b0;
    end else if (fire) begin
      rcvd_q <= rcvd_q + 1'b1;
      if (rsp_fault_i && !fault_q) begin
        fault_q <= 1'b1;
        trunc_q <= rcvd_q;
      end
    end
  end
endmodule

// File: rtl/ffload_seq.sv
module ffload_seq
  import ffload_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int MAX_ELEMS = 8,
  localparam int CW = $clog2(MAX_ELEMS + 1),
  localparam int IW = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [CW-1:0] count_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  input  logic          req_ready_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          rsp_fault_i,
  output logic          rsp_ready_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [DW-1:0] wr_data_o,
  output logic          done_o,
  output logic [CW-1:0] loaded_cnt_o,
  output logic          trap_o
);
  seq_st_e       st_q;
  logic [CW-1:0] total_q, eff_cnt, issued, rcvd, rcvd_nx, fault_idx;
  logic          start_ok, halt, rsp_fire, finish;
  logic          done_q, trap_q;
  logic [CW-1:0] cnt_q;

  assign start_ok = start_i && (st_q == ST_IDLE);
  assign eff_cnt  = (count_i > CW'(MAX_ELEMS)) ? CW'(MAX_ELEMS) : count_i;
  assign rsp_fire = rsp_valid_i && rsp_ready_o;
  assign rcvd_nx  = rcvd + CW'(rsp_fire);
  // all issued answered, and either faulted or the full count went out
  assign finish   = (st_q == ST_RUN) && (rcvd_nx == issued) && (halt || issued == total_q);

  ffload_issue #(.AW(AW), .CW(CW)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_ok),
    .base_i      (base_i),
    .stride_i    (stride_i),
    .run_i       ((st_q == ST_RUN) && !halt),
    .total_i     (total_q),
    .req_ready_i (req_ready_i),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .issued_o    (issued)
  );

  ffload_retire #(.DW(DW), .CW(CW), .IW(IW)) u_retire (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_ok),
    .active_i    (st_q == ST_RUN),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .rsp_fault_i (rsp_fault_i),
    .rsp_ready_o (rsp_ready_o),
    .wr_en_o     (wr_en_o),
    .wr_idx_o    (wr_idx_o),
    .wr_data_o   (wr_data_o),
    .rcvd_o      (rcvd),
    .halt_o      (halt),
    .fault_idx_o (fault_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      total_q <= '0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      trap_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        total_q <= eff_cnt;
        cnt_q   <= '0;
        trap_q  <= 1'b0;
        if (eff_cnt == '0) done_q <= 1'b1;
        else               st_q   <= ST_RUN;
      end else if (finish) begin
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
        if (halt && fault_idx == '0) begin
          trap_q <= 1'b1;
          cnt_q  <= total_q;
        end else if (halt) begin
          cnt_q <= fault_idx;
        end else begin
          cnt_q <= total_q;
        end
      end
    end
  end

  assign done_o       = done_q;
  assign loaded_cnt_o = cnt_q;
  assign trap_o       = trap_q;
endmodule

// File: rtl/ffload_seq_chk.sv
module ffload_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_o,
  input logic [AW-1:0] req_addr_o,
  input logic          req_ready_i,
  input logic          rsp_valid_i,
  input logic          rsp_fault_i,
  input logic          rsp_ready_o,
  input logic          wr_en_o,
  input logic          done_o,
  input logic          trap_o
);
  logic past_ok_q, fault_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok_q    <= 1'b0;
      fault_seen_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      if (done_o) fault_seen_q <= 1'b0;
      else if (rsp_valid_i && rsp_ready_o && rsp_fault_i) fault_seen_q <= 1'b1;
    end
  end

  assert_wr_on_good_rsp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (rsp_valid_i && rsp_ready_o && !rsp_fault_i));

  assert_addr_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(req_valid_o) && !$past(req_ready_i) && req_valid_o)
      |-> req_addr_o == $past(req_addr_o));

  assert_no_req_after_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_ready_o && rsp_fault_i) |=> !req_valid_o);

  assert_no_wr_after_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_seen_q |-> !wr_en_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_at_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rsp_ready_o && !req_valid_o));

  assert_trap_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $rose(trap_o)) |-> done_o);
endmodule

bind ffload_seq ffload_seq_chk #(.AW(AW), .DW(DW), .CW(CW), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_addr_o  (req_addr_o),
  .req_ready_i (req_ready_i),
  .rsp_valid_i (rsp_valid_i),
  .rsp_fault_i (rsp_fault_i),
  .rsp_ready_o (rsp_ready_o),
  .wr_en_o     (wr_en_o),
  .done_o      (done_o),
  .trap_o      (trap_o)
);

// File: tb/sim_ffload_seq.sv
`timescale 1ns/1ps
module sim_ffload_seq;
  localparam int AW = 16, DW = 16, MAXE = 8, CW = 4, IW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0, stride_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          req_valid_o, req_ready_i = 1'b0;
  logic [AW-1:0] req_addr_o;
  logic          rsp_valid_i = 1'b0, rsp_fault_i = 1'b0, rsp_ready_o;
  logic [DW-1:0] rsp_data_i = '0;
  logic          wr_en_o, done_o, trap_o;
  logic [IW-1:0] wr_idx_o;
  logic [DW-1:0] wr_data_o;
  logic [CW-1:0] loaded_cnt_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  ffload_seq #(.AW(AW), .DW(DW), .MAX_ELEMS(MAXE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .count_i(count_i), .req_valid_o(req_valid_o),
    .req_addr_o(req_addr_o), .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i),
    .rsp_data_i(rsp_data_i), .rsp_fault_i(rsp_fault_i), .rsp_ready_o(rsp_ready_o),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .loaded_cnt_o(loaded_cnt_o), .trap_o(trap_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mkdata(input logic [AW-1:0] a);
    return a ^ 16'h5A3C;
  endfunction

  function automatic bit thr(input int pat, input int cyc, input int which);
    if (pat == 0) return 1'b1;
    if (pat == 1) return ((cyc + which) % 2) == 0;
    return ((cyc * 5 + which * 3) % 7) < 4;
  endfunction

  task automatic run_case(input logic [AW-1:0] b, input logic [AW-1:0] s,
                          input int cnt, input int fat, input int pat);
    int eff, nreq, nrsp, cyc, qh, qt;
    int qi[16];
    bit fseen, exp_done, got_done, bfault, exp_wr, exp_trap;
    int exp_cnt;
    logic [AW-1:0] ea;
    eff = (cnt > MAXE) ? MAXE : cnt;
    nreq = 0; nrsp = 0; cyc = 0; qh = 0; qt = 0;
    fseen = 0; got_done = 0;
    exp_trap = (fat == 0) && (eff > 0);
    exp_cnt  = (fat > 0 && fat < eff) ? fat : eff;
    @(negedge clk);
    start_i = 1'b1; base_i = b; stride_i = s; count_i = cnt[CW-1:0];
    req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_fault_i = 1'b0;
    exp_done = (eff == 0);
    while (!got_done && cyc < 300) begin
      @(negedge clk);
      start_i = 1'b0;
      if (cyc == 2 && !done_o) begin
        start_i = 1'b1; base_i = ~b; stride_i = s + 16'd5; count_i = 4'd3; // R9
      end
      req_ready_i = thr(pat, cyc, 0);
      rsp_valid_i = (qt > qh) && thr(pat, cyc, 1);
      if (qt > qh) begin
        ea = b + AW'(qi[qh]) * s;
        rsp_data_i  = mkdata(ea);
        rsp_fault_i = (qi[qh] == fat);
      end else begin
        rsp_data_i = '0; rsp_fault_i = 1'b0;
      end
      #1;
      chk(done_o == exp_done, "R5/R8 done timing", done_o, exp_done);
      if (cyc == 0 && eff != 0)
        chk(loaded_cnt_o == 0 && !trap_o, "R10 cleared on start", loaded_cnt_o, 0);
      if (done_o) begin
        got_done = 1;
        chk(trap_o == exp_trap, "R6 trap", trap_o, exp_trap);
        chk(loaded_cnt_o == CW'(exp_cnt), "R5/R6/R7 loaded count", loaded_cnt_o, exp_cnt);
        chk(nreq == nrsp, "R7 drained", nrsp, nreq);
        if (fat < 0 || fat >= eff) chk(nreq == eff, "R3 request total", nreq, eff);
        chk(!rsp_ready_o && !req_valid_o, "R11 idle at done", rsp_ready_o, 0);
      end else begin
        chk(rsp_ready_o == 1'b1, "R11 ready while busy", rsp_ready_o, 1);
      end
      exp_done = 0;
      bfault = rsp_valid_i && rsp_ready_o && rsp_fault_i;
      if (req_valid_o) begin
        ea = b + AW'(nreq) * s;
        chk(!(fseen || bfault), "R7 no request after fault", req_valid_o, 0);
        chk(req_addr_o == ea, "R2 address", req_addr_o, ea);
        chk(nreq < eff, "R3 request limit", nreq, eff);
        if (req_ready_i) begin
          qi[qt % 16] = nreq; qt++; nreq++;
        end
      end
      if (rsp_valid_i && rsp_ready_o) begin
        exp_wr = !rsp_fault_i && !fseen;
        chk(wr_en_o == exp_wr, "R4/R7 write enable", wr_en_o, exp_wr);
        if (exp_wr) begin
          chk(wr_idx_o == IW'(qi[qh % 16]), "R4 write index", wr_idx_o, qi[qh % 16]);
          chk(wr_data_o == rsp_data_i, "R4 write data", wr_data_o, rsp_data_i);
        end
        if (rsp_fault_i) fseen = 1;
        qh++; nrsp++;
        if (nrsp == nreq && (fseen || nrsp == eff)) exp_done = 1;
      end else begin
        chk(wr_en_o == 1'b0, "R4 no stray write", wr_en_o, 0);
      end
      cyc++;
    end
    if (!got_done) chk(1'b0, "R5 operation never completed", 0, 1);
    @(negedge clk);
    start_i = 1'b0; req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_fault_i = 1'b0;
    #1;
    chk(done_o == 1'b0, "R10 done pulse width", done_o, 0);
    chk(loaded_cnt_o == CW'(exp_cnt) && trap_o == exp_trap, "R10 result held", loaded_cnt_o, exp_cnt);
    chk(!rsp_ready_o && !req_valid_o, "R11 idle after done", rsp_ready_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] strides[3];
    strides[0] = 16'd1; strides[1] = 16'd4; strides[2] = 16'hFFFD;
    repeat (3) @(negedge clk);
    #1;
    chk(!req_valid_o && !rsp_ready_o && !wr_en_o && !done_o && !trap_o && loaded_cnt_o == 0,
        "R1 reset state", {req_valid_o, rsp_ready_o, wr_en_o, done_o, trap_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk(!req_valid_o && !rsp_ready_o && !done_o && loaded_cnt_o == 0,
        "R1 after reset", {req_valid_o, rsp_ready_o, done_o}, 0);
    for (int c = 0; c <= 10; c++) begin
      for (int f = -1; f < ((c > MAXE) ? MAXE : c); f++) begin
        for (int si = 0; si < 3; si++) begin
          for (int p = 0; p < 3; p++) begin
            run_case(16'h1000 + AW'(c * 37) + AW'(f * 3), strides[si], c, f, p);
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule